// File: doc/BRIEF.md
# Banked Operand Fetch with Reuse Cache

This block is the operand-read stage for instructions that take three source registers. The register file is split into two banks by the lowest bit of the register index. Each bank supplies two 32-bit values per cycle, so it is 64 bits wide. Alongside the banks sits a small reuse cache with one entry per source position. An instruction supplies its three source indices, a 4-bit reuse-flag field and a warp-switch marker. The stage returns the three source values together, marked by a one-cycle valid pulse.

A source whose cache entry is valid and holds the same register index is served from the cache. It costs no bank read. The remaining reads are counted per bank. Only when all three are real reads from the same bank does the stage split the work: two reads happen in the accept cycle and the third in one extra cycle, during which it refuses new requests. The compiler's reuse flags decide which fetched values are kept. A warp switch empties the cache and disables the flags of that instruction. A simple write port fills the register file and drops any cache entry that holds the written register.

Top module: `operand_fetch`

## Requirements
- R1: After reset `reqReady` is 1, `outValid` is 0, and every register reads as zero until it is written.
- R2: A value written through the write port is returned by every later request that names that register, with `opA`, `opB` and `opC` carrying the values of `srcIdx0`, `srcIdx1` and `srcIdx2`.
- R3: A request without a bank conflict produces `outValid` = 1 in the cycle after it is accepted, and `reqReady` stays 1, so a request may be accepted every cycle.
- R4: The bank of a register is bit 0 of its index. When all three sources miss the cache and share a bank (repeats of one register count), `reqReady` is 0 for exactly one cycle after acceptance, and `outValid` rises two cycles after acceptance.
- R5: Sources that span both banks, or with at most two in one bank, never cause a stall.
- R6: Reuse flag bit j (bit 0 for `srcIdx0`, bit 1 for `srcIdx1`, bit 2 for `srcIdx2`) keeps that source's value in cache slot j. A later request with the same index in the same position hits, and it still returns the correct value. This holds also when the value is fetched in the extra cycle. Bit 3 has no source and no effect.
- R7: A cache hit is not counted toward a conflict, so three same-bank sources with one hit do not stall.
- R8: A cache slot serves only its own source position. A cached index that appears in another position is read from the bank.
- R9: A request with `warpSwitch` = 1 gets no hits and captures nothing, whatever its reuse flags. It also clears every cache entry.
- R10: A write to a register held in a cache slot invalidates that slot. Later reads return the new value from the bank, and writes to other registers leave the slot valid.
- R11: Every accepted request produces exactly one `outValid` pulse, and at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Stage accepts a request this cycle |
| srcIdx0 | input | 8 | First source register index |
| srcIdx1 | input | 8 | Second source register index |
| srcIdx2 | input | 8 | Third source register index |
| reuseFlags | input | 4 | Per-position keep flags, bit 0 for the first source |
| warpSwitch | input | 1 | Request comes from a different warp than the last one |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 8 | Register written |
| wrData | input | 32 | Write value |
| outValid | output | 1 | One-cycle pulse: operand values are valid |
| opA | output | 32 | Value of the first source |
| opB | output | 32 | Value of the second source |
| opC | output | 32 | Value of the third source |

## Verification
The checker watches the handshake timing on every cycle:
- a stall lasts exactly one cycle and is followed by valid data;
- requests that span both banks never stall;
- a warp-switch request whose sources share a bank always stalls;
- no more than one request is ever in flight.

Whether a stall was avoided by a genuine cache hit, that the returned values are right, and that slots are invalidated by writes only for the matching register depend on history spanning several requests. The bench's directed scenarios show these by tracking cache contents and register values.

// File: rtl/ofetch_pkg.sv
package ofetch_pkg;

  localparam int SRC_COUNT = 3;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_EXTRA = 1'b1
  } fetchState_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic takeAll;    // all three values load now
    logic takeFirst;  // conflict: first two values load now
    logic takeLast;   // extra cycle: third value loads now
  } fetchStrobe_t;

endpackage

// File: rtl/ofetch_bank.sv
// One register bank: two 32-bit read ports (64 bits per cycle) and one write port.
module ofetch_bank #(
  parameter int ROWS   = 128,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ROW_W-1:0]  rdRow0,
  input  logic [ROW_W-1:0]  rdRow1,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1
);

  logic [DATA_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) store[r] <= '0;
    end else if (wrEn) begin
      store[wrRow] <= wrData;
    end
  end

  assign rdData0 = store[rdRow0];
  assign rdData1 = store[rdRow1];

endmodule

// File: rtl/ofetch_ctrl.sv
module ofetch_ctrl
  import ofetch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         conflict,
  output logic         reqReady,
  output fetchStrobe_t stb
);

  fetchState_t state, stateNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb.accept    = reqValid && reqReady;
    stb.takeAll   = stb.accept && !conflict;
    stb.takeFirst = stb.accept && conflict;
    stb.takeLast  = (state == ST_EXTRA);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (stb.takeFirst) stateNext = ST_EXTRA;
      ST_EXTRA: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ofetch_dp.sv
module ofetch_dp
  import ofetch_pkg::*;
#(
  parameter int NUM_REGS = 256,
  parameter int DATA_W   = 32,
  parameter int FLAG_W   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ROWS    = NUM_REGS / 2,
  localparam int ROW_W   = IDX_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      stb,
  input  logic [IDX_W-1:0]  srcIdx0,
  input  logic [IDX_W-1:0]  srcIdx1,
  input  logic [IDX_W-1:0]  srcIdx2,
  input  logic [FLAG_W-1:0] reuseFlags,
  input  logic              warpSwitch,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              conflict,
  output logic              outValid,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] opC
);

  localparam int LAST = SRC_COUNT - 1;

  logic [IDX_W-1:0]  idx       [SRC_COUNT];
  logic              hit       [SRC_COUNT];
  logic              miss      [SRC_COUNT];
  logic              bankOf    [SRC_COUNT];
  logic [1:0]        rank      [SRC_COUNT];
  logic [DATA_W-1:0] fetched   [SRC_COUNT];
  logic [SRC_COUNT-1:0] flagEff;

  logic              slotValid [SRC_COUNT];
  logic [IDX_W-1:0]  slotTag   [SRC_COUNT];
  logic [DATA_W-1:0] slotData  [SRC_COUNT];

  logic [ROW_W-1:0]  bankAddr  [2][2];
  logic [DATA_W-1:0] bankRd    [2][2];

  logic [IDX_W-1:0]  latIdxLast;
  logic              latFlagLast;
  logic [DATA_W-1:0] lastVal;
  logic [DATA_W-1:0] opReg     [SRC_COUNT];
  logic              unusedFlags;

  assign idx[0] = srcIdx0;
  assign idx[1] = srcIdx1;
  assign idx[2] = srcIdx2;

  // Flags beyond the source count have no slot to fill.
  assign flagEff     = warpSwitch ? '0 : reuseFlags[SRC_COUNT-1:0];
  assign unusedFlags = ^reuseFlags[FLAG_W-1:SRC_COUNT];

  // ---------------- lookup and bank routing ----------------
  always_comb begin
    for (int j = 0; j < SRC_COUNT; j++) begin
      hit[j]    = !warpSwitch && slotValid[j] && (slotTag[j] == idx[j]);
      miss[j]   = !hit[j];
      bankOf[j] = idx[j][0];
    end
    for (int j = 0; j < SRC_COUNT; j++) begin
      rank[j] = 2'd0;
      for (int k = 0; k < j; k++) begin
        if (miss[k] && (bankOf[k] == bankOf[j])) rank[j] = rank[j] + 2'd1;
      end
    end
  end

  assign conflict = miss[0] && miss[1] && miss[2] &&
                    (bankOf[0] == bankOf[1]) && (bankOf[1] == bankOf[2]);

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      bankAddr[b][0] = '0;
      bankAddr[b][1] = '0;
    end
    if (stb.takeLast) begin
      bankAddr[latIdxLast[0]][0] = latIdxLast[IDX_W-1:1];
    end else begin
      for (int j = 0; j < SRC_COUNT; j++) begin
        if (miss[j] && (rank[j] < 2'd2))
          bankAddr[bankOf[j]][rank[j][0]] = idx[j][IDX_W-1:1];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < SRC_COUNT; j++)
      fetched[j] = hit[j] ? slotData[j] : bankRd[bankOf[j]][rank[j][0]];
  end

  assign lastVal = bankRd[latIdxLast[0]][0];

  // ---------------- banks ----------------
  for (genvar b = 0; b < 2; b++) begin : gBank
    ofetch_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) uBank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrEn && (wrIdx[0] == 1'(b))),
      .wrRow  (wrIdx[IDX_W-1:1]),
      .wrData (wrData),
      .rdRow0 (bankAddr[b][0]),
      .rdRow1 (bankAddr[b][1]),
      .rdData0(bankRd[b][0]),
      .rdData1(bankRd[b][1])
    );
  end

  // ---------------- latched third source for the extra cycle ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latIdxLast  <= '0;
      latFlagLast <= 1'b0;
    end else if (stb.accept) begin
      latIdxLast  <= idx[LAST];
      latFlagLast <= flagEff[LAST];
    end
  end

  // ---------------- reuse slots ----------------
  for (genvar s = 0; s < SRC_COUNT; s++) begin : gSlot
    logic              capNow;
    logic [IDX_W-1:0]  capTag;
    logic [DATA_W-1:0] capVal;
    logic              fromLast;

    assign fromLast = (s == LAST) && stb.takeLast;
    assign capNow   = (flagEff[s] && (stb.takeAll || (stb.takeFirst && (s < LAST))))
                    || (fromLast && latFlagLast);
    assign capTag   = fromLast ? latIdxLast : idx[s];
    assign capVal   = fromLast ? lastVal : fetched[s];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[s] <= 1'b0;
        slotTag[s]   <= '0;
        slotData[s]  <= '0;
      end else if (stb.accept && warpSwitch) begin
        slotValid[s] <= 1'b0;
      end else if (capNow) begin
        slotTag[s]   <= capTag;
        slotData[s]  <= capVal;
        slotValid[s] <= !(wrEn && (wrIdx == capTag));
      end else if (wrEn && (wrIdx == slotTag[s])) begin
        slotValid[s] <= 1'b0;
      end
    end
  end

  // ---------------- operand registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      for (int j = 0; j < SRC_COUNT; j++) opReg[j] <= '0;
    end else begin
      outValid <= stb.takeAll || stb.takeLast;
      for (int j = 0; j < SRC_COUNT; j++) begin
        if (stb.takeAll || (stb.takeFirst && (j < LAST))) opReg[j] <= fetched[j];
      end
      if (stb.takeLast) opReg[LAST] <= lastVal;
    end
  end

  assign opA = opReg[0];
  assign opB = opReg[1];
  assign opC = opReg[2];

endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
  import ofetch_pkg::*;
#(
  parameter int NUM_REGS = 256,
  parameter int DATA_W   = 32,
  parameter int FLAG_W   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [IDX_W-1:0]  srcIdx0,
  input  logic [IDX_W-1:0]  srcIdx1,
  input  logic [IDX_W-1:0]  srcIdx2,
  input  logic [FLAG_W-1:0] reuseFlags,
  input  logic              warpSwitch,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              outValid,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] opC
);

  fetchStrobe_t stb;
  logic         conflict;

  ofetch_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .conflict(conflict),
    .reqReady(reqReady),
    .stb     (stb)
  );

  ofetch_dp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .FLAG_W(FLAG_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcIdx0   (srcIdx0),
    .srcIdx1   (srcIdx1),
    .srcIdx2   (srcIdx2),
    .reuseFlags(reuseFlags),
    .warpSwitch(warpSwitch),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .conflict  (conflict),
    .outValid  (outValid),
    .opA       (opA),
    .opB       (opB),
    .opC       (opC)
  );

endmodule

// File: rtl/ofetch_chk.sv
module ofetch_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic bank0,
  input logic bank1,
  input logic bank2,
  input logic warpSwitch,
  input logic outValid
);

  logic [1:0] inFlight;
  logic       accepted;
  logic       sameBank;

  assign accepted = reqValid && reqReady;
  assign sameBank = (bank0 == bank1) && (bank1 == bank2);

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= 2'd0;
    else       inFlight <= inFlight + 2'(accepted) - 2'(outValid);
  end

  a_r4_stall_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  a_r4_stall_then_valid: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> outValid);

  a_r5_split_banks_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !sameBank) |=> reqReady);

  a_r9_warp_no_hits: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && warpSwitch && sameBank) |=> !reqReady);

  a_r3_stall_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));

  a_r11_valid_has_request: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight == 2'd1));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 2'd1);

endmodule

bind operand_fetch ofetch_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .bank0     (srcIdx0[0]),
  .bank1     (srcIdx1[0]),
  .bank2     (srcIdx2[0]),
  .warpSwitch(warpSwitch),
  .outValid  (outValid)
);

// File: tb/operand_fetch_test.sv
`timescale 1ns/1ps
module operand_fetch_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  srcIdx0 = '0, srcIdx1 = '0, srcIdx2 = '0;
  logic [3:0]  reuseFlags = '0;
  logic        warpSwitch = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        outValid;
  logic [31:0] opA, opB, opC;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  operand_fetch uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .srcIdx0(srcIdx0), .srcIdx1(srcIdx1), .srcIdx2(srcIdx2),
    .reuseFlags(reuseFlags), .warpSwitch(warpSwitch),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .outValid(outValid), .opA(opA), .opB(opB), .opC(opC)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input int r, input logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 8'(r); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    model[r] = v;
  endtask

  task automatic checkOps(input string req, input int i0, input int i1, input int i2);
    check(req, "opA", opA, model[i0]);
    check(req, "opB", opB, model[i1]);
    check(req, "opC", opC, model[i2]);
  endtask

  // Drives one request; expStall says whether the requirement predicts the split read.
  task automatic issue(input string req, input int i0, input int i1, input int i2,
                       input logic [3:0] flags, input bit warp, input bit expStall);
    @(negedge clk);
    check(req, "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; srcIdx0 = 8'(i0); srcIdx1 = 8'(i1); srcIdx2 = 8'(i2);
    reuseFlags = flags; warpSwitch = warp;
    @(negedge clk);
    reqValid = 1'b0; warpSwitch = 1'b0; reuseFlags = '0;
    if (expStall) begin
      check(req, "ready low in extra cycle", 32'(reqReady), 32'd0);
      check(req, "no valid in extra cycle", 32'(outValid), 32'd0);
      @(negedge clk);
      check(req, "ready back", 32'(reqReady), 32'd1);
    end else begin
      check(req, "ready kept high", 32'(reqReady), 32'd1);
    end
    check(req, "outValid", 32'(outValid), 32'd1);
    checkOps(req, i0, i1, i2);
    @(negedge clk);
    check(req, "single pulse", 32'(outValid), 32'd0);
  endtask

  task automatic testReset();
    check("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    check("R1", "outValid after reset", 32'(outValid), 32'd0);
    issue("R1", 40, 41, 42, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic testBasic();
    for (int r = 0; r < 16; r++) writeReg(r, 32'h1000_0000 + 32'(r) * 32'h0101_0101);
    issue("R2", 1, 2, 3, 4'b0000, 1'b0, 1'b0);
    issue("R5", 4, 5, 4, 4'b0000, 1'b0, 1'b0);
    issue("R5", 2, 2, 7, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic testConflict();
    issue("R4", 1, 3, 5, 4'b0000, 1'b0, 1'b1);
    issue("R4", 0, 2, 8, 4'b0000, 1'b0, 1'b1);
    issue("R4", 6, 6, 6, 4'b0000, 1'b0, 1'b1);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    reqValid = 1'b1; srcIdx0 = 8'd2; srcIdx1 = 8'd3; srcIdx2 = 8'd4;
    @(negedge clk);
    check("R3", "first valid", 32'(outValid), 32'd1);
    check("R3", "ready held", 32'(reqReady), 32'd1);
    checkOps("R3", 2, 3, 4);
    srcIdx0 = 8'd9; srcIdx1 = 8'd10; srcIdx2 = 8'd12;
    @(negedge clk);
    reqValid = 1'b0;
    check("R3", "second valid", 32'(outValid), 32'd1);
    checkOps("R3", 9, 10, 12);
    @(negedge clk);
    check("R11", "pulses end", 32'(outValid), 32'd0);
  endtask

  task automatic testReuse();
    issue("R6", 1, 3, 5, 4'b1001, 1'b0, 1'b1);   // slot0 <- r1; bit 3 inert
    issue("R7", 1, 7, 9, 4'b0000, 1'b0, 1'b0);   // slot0 hit removes conflict
    issue("R8", 7, 1, 9, 4'b0000, 1'b0, 1'b1);   // r1 in position 1: no hit
    issue("R6", 3, 5, 11, 4'b0100, 1'b0, 1'b1);  // slot2 filled in extra cycle
    issue("R6", 13, 15, 11, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic testWarp();
    issue("R9", 1, 3, 5, 4'b0111, 1'b1, 1'b1);   // cached r1 ignored
    issue("R9", 1, 3, 5, 4'b0000, 1'b0, 1'b1);   // cleared, nothing captured
  endtask

  task automatic testInvalidate();
    issue("R10", 5, 3, 7, 4'b0010, 1'b0, 1'b1);  // slot1 <- r3
    issue("R10", 9, 3, 11, 4'b0000, 1'b0, 1'b0);
    writeReg(13, 32'hDEAD_0013);
    issue("R10", 9, 3, 11, 4'b0000, 1'b0, 1'b0); // other write keeps slot
    writeReg(3, 32'hCAFE_0003);
    issue("R10", 9, 3, 11, 4'b0000, 1'b0, 1'b1); // slot dropped, new value read
  endtask

  initial begin
    for (int r = 0; r < 256; r++) model[r] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testConflict();
    testBackToBack();
    testReuse();
    testWarp();
    testInvalidate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule